// File: doc/BRIEF.md
# Two-Wire Single-Register Slave Front-End

This block is the bus-facing half of a tiny configuration register that sits on a two-wire (I2C-style) serial bus. A fast system clock samples the raw clock and data lines through synchronizers and a majority filter. The block then finds the start, repeated-start and stop conditions, shifts in the address and data bytes, and pulls the data line low for acknowledges through an open-drain enable. A read returns one byte, taken from a register-side input.

Toward the register logic it gives a one-cycle write strobe with the data byte. It takes a read-data byte and a busy flag, which is high while a slow internal write cycle runs. It also brings out one-cycle start and stop pulses for neighbouring logic. A write is accepted only when it is complete and carries exactly one data byte. Any other sequence is dropped without touching the register.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe` is 0 and `wr_stb` stays 0 while the bus is idle.
- R2: The first byte after a start is acknowledged only when its upper seven bits equal 1011000. Bit 0 selects the direction: 0xB0 writes and 0xB1 reads. Any other value is not acknowledged, and later bytes get no acknowledge until the next start.
- R3: A write is the device byte 0xB0, the register select byte 0xFF and one data byte, each acknowledged. A stop that directly follows the data byte's acknowledge clock raises `wr_stb` with `wr_data` equal to that data byte.
- R4: `wr_stb` is high for exactly one cycle, and only in the cycle after a `stop_pulse`.
- R5: A second data byte in the same write is not acknowledged, and no strobe follows at the later stop.
- R6: A stop that arrives before the data byte and its acknowledge clock are complete ends the transfer with no strobe.
- R7: A register select byte other than 0xFF is not acknowledged, and the rest of that transfer (data byte included) is ignored.
- R8: While `busy` is high the block acknowledges nothing and raises no strobe.
- R9: After an acknowledged 0xB1, the block shifts out `rd_data` most significant bit first, one bit per clock, and releases the line for the ninth clock. It then returns to idle with or without a stop, so bytes clocked afterwards get no acknowledge.
- R10: `sda_oe` changes only while the filtered clock line is low.
- R11: `start_pulse` marks a high-to-low data transition while the clock is high, and `stop_pulse` marks a low-to-high one, each for one cycle per condition.
- R12: A data-line glitch lasting one system clock while the clock line is high produces no start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line, read back from the wire |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| wr_stb | output | 1 | One-cycle write request toward the register |
| wr_data | output | 8 | Data byte to store on `wr_stb` |
| rd_data | input | 8 | Register byte returned on reads |
| busy | input | 1 | Register is in a slow write cycle; the bus is ignored |
| start_pulse | output | 1 | One-cycle pulse per start or repeated start |
| stop_pulse | output | 1 | One-cycle pulse per stop |

## Verification
A wrong byte phase or bit count shows at the ports within one bus byte. An acknowledge appears on the wrong clock or is missing, a read byte comes out shifted, or `wr_stb` fires at a stop that should have discarded the write. A commit flag left set from an earlier transfer shows only at a later stop, so the directed cases run back to back: aborted and rejected transfers come right after good ones. The strobe count is then checked after every stop. Filter or edge-detector faults show as a missing or spurious `start_pulse`, which is counted around each condition and around an injected glitch.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire slave front-end.
// Assumes nothing beyond SystemVerilog 2017 enums.
package tw_pkg;
    // Bus-level sequencer state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TACK,
        ST_IGNORE
    } tw_state_t;

    // Which byte of the transfer is being received.
    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA,
        PH_EXTRA
    } tw_phase_t;
endpackage

// File: rtl/tw_line_filter.sv
// Synchronizes one asynchronous bus line and removes short glitches by a
// majority vote over the last TAPS synchronized samples.
// Assumes the line idles high (pulled up) and TAPS is odd.
module tw_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HALF = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        win_q;

    // Synchronizer chain, then the sample window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Registered majority vote of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= 1'b1;
        else        dout <= ($countones(win_q) > HALF);
    end
endmodule

// File: rtl/tw_cond_detect.sv
// Finds bus events from the filtered lines: clock edges, start and stop.
// Assumes both inputs are already synchronous and glitch-free.
module tw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_d, sda_d;

    // Previous-cycle copies of the filtered lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Event decode: data moving while the clock stays high is a condition.
    always_comb begin
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
        start_p  = scl_f & scl_d & sda_d & ~sda_f;
        stop_p   = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/tw_slave_fsm.sv
// Byte sequencer: shifts bytes, decides acknowledges, serves one-byte reads
// and commits a write only at a stop right after the single data byte.
// Assumes event inputs are one-cycle pulses from tw_cond_detect.
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter int             DW      = 8,
    parameter logic [DW-2:0]  DEV_ID  = 7'b1011000,
    parameter logic [DW-1:0]  REG_SEL = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_f,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_p,
    input  logic          stop_p,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    tw_state_t       state;
    tw_phase_t       phase;
    logic [CW-1:0]   cnt;
    logic [DW-1:0]   sh;
    logic [DW-1:0]   data_q;
    logic            rd_mode;
    logic            ack_ok;
    logic            commit_ok;

    // Acknowledge decision for the byte just received.
    always_comb begin
        unique case (phase)
            PH_DEV:  ack_ok = (sh[DW-1:1] == DEV_ID);
            PH_REG:  ack_ok = (sh == REG_SEL);
            PH_DATA: ack_ok = 1'b1;
            default: ack_ok = 1'b0;
        endcase
    end

    // A stop commits only right after the data byte's acknowledge clock;
    // the clock rise before a stop samples at most one bit.
    assign commit_ok = (state == ST_RX) && (phase == PH_EXTRA) && (cnt <= 1);

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            cnt     <= '0;
            sh      <= '0;
            data_q  <= '0;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (busy) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (stop_p) begin
                if (commit_ok) begin
                    wr_stb  <= 1'b1;
                    wr_data <= data_q;
                end
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_p) begin
                state  <= ST_RX;
                phase  <= PH_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[DW-2:0], sda_f};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            state  <= ST_ACK;
                            sda_oe <= ack_ok;
                            if (phase == PH_DEV)  rd_mode <= sh[0];
                            if (phase == PH_DATA) data_q  <= sh;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            if (!sda_oe) begin
                                state <= ST_IGNORE;
                            end else begin
                                unique case (phase)
                                    PH_DEV: begin
                                        if (rd_mode) begin
                                            state  <= ST_TX;
                                            sh     <= rd_data;
                                            sda_oe <= ~rd_data[DW-1];
                                        end else begin
                                            state <= ST_RX;
                                            phase <= PH_REG;
                                        end
                                    end
                                    PH_REG: begin
                                        state <= ST_RX;
                                        phase <= PH_DATA;
                                    end
                                    PH_DATA: begin
                                        state <= ST_RX;
                                        phase <= PH_EXTRA;
                                    end
                                    default: state <= ST_IGNORE;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                state  <= ST_TACK;
                                sda_oe <= 1'b0;
                            end else begin
                                sh     <= {sh[DW-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                                sda_oe <= ~sh[DW-2];
                            end
                        end
                    end
                    ST_TACK: begin
                        if (scl_fall) state <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_ctrl_slave.sv
// Top of the two-wire single-register slave: filters both lines, detects
// bus events and runs the byte sequencer.
// Assumes clk is at least ~20x the bus clock so filter delay fits in a
// clock-low phase.
module tw_ctrl_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_data,
    input  logic          busy,
    output logic          start_pulse,
    output logic          stop_pulse
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic scl_filt, sda_filt;
    logic scl_rise, scl_fall;

    assign raw_lines = {scl_in, sda_in};
    assign scl_filt  = filt_lines[1];
    assign sda_filt  = filt_lines[0];

    // One identical filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        tw_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .TAPS       (FILT_TAPS)
        ) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    tw_cond_detect i_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_filt),
        .sda_f   (sda_filt),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_p (start_pulse),
        .stop_p  (stop_pulse)
    );

    tw_slave_fsm #(.DW(DW)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_f   (sda_filt),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_p (start_pulse),
        .stop_p  (stop_pulse),
        .busy    (busy),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr_stb  (wr_stb),
        .wr_data (wr_data)
    );
endmodule

// File: rtl/tw_ctrl_slave_chk.sv
// Property checker for tw_ctrl_slave, attached by bind below.
// Assumes synchronous active-low reset.
module tw_ctrl_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic wr_stb,
    input logic busy,
    input logic stop_pulse,
    input logic scl_filt
);
    AST_STB_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(stop_pulse)); // R4
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4
    AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !sda_oe); // R8
    AST_BUSY_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(busy)); // R8
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(busy)) |-> !$past(scl_filt)); // R10
endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .stop_pulse(stop_pulse),
    .scl_filt  (scl_filt)
);

// File: tb/test_tw_ctrl_slave.sv
// Directed bench for tw_ctrl_slave: a bus master model, one task per scenario.
module test_tw_ctrl_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // system clocks per quarter bus bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic sda_oe, wr_stb, start_pulse, stop_pulse;
    logic [7:0] wr_data;
    logic sda_line;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    int oe_high_changes = 0;
    logic [7:0] stb_val = 8'h00;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    tw_ctrl_slave i_tw_ctrl_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .busy       (busy),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin stb_cnt++; stb_val = wr_data; end
            if (start_pulse) start_cnt++;
            if (stop_pulse) stop_cnt++;
            if (sda_oe != prev_oe && scl_m && prev_scl) oe_high_changes++;
        end
        prev_oe = sda_oe;
        prev_scl = scl_m;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        end
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(Q); sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(4*Q);
    endtask

    task automatic put_bit(input logic b);
        wclk(Q); sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        acked = (sda_line == 1'b0);
        wclk(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
            b[i] = sda_line;
            wclk(Q); scl_m = 1'b0;
        end
        put_bit(~master_ack);
    endtask

    task automatic t_reset();
        check("R1 oe after reset", sda_oe, 1'b0);
        wclk(20);
        check("R1 no strobe idle", stb_cnt, 0);
    endtask

    task automatic t_write(input logic [7:0] d);
        logic a0, a1, a2;
        int s0, st0, sp0;
        s0 = stb_cnt; st0 = start_cnt; sp0 = stop_cnt;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        send_byte(d, a2);
        bus_stop();
        check("R2 device byte ack", a0, 1'b1);
        check("R3 register byte ack", a1, 1'b1);
        check("R3 data byte ack", a2, 1'b1);
        check("R4 one strobe", stb_cnt - s0, 1);
        check("R3 strobe data", stb_val, d);
        check("R11 start count", start_cnt - st0, 1);
        check("R11 stop count", stop_cnt - sp0, 1);
    endtask

    task automatic t_bad_dev();
        logic a0, a1;
        int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'hFF, a1);
        bus_stop();
        check("R2 wrong device nack", a0, 1'b0);
        check("R2 ignored until start", a1, 1'b0);
        check("R2 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_bad_reg();
        logic a0, a1, a2;
        int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'h10, a1);
        send_byte(8'h33, a2);
        bus_stop();
        check("R7 device ack", a0, 1'b1);
        check("R7 wrong register nack", a1, 1'b0);
        check("R7 data ignored", a2, 1'b0);
        check("R7 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_extra();
        logic a0, a1, a2, a3;
        int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        bus_stop();
        check("R5 first data ack", a2, 1'b1);
        check("R5 second data nack", a3, 1'b0);
        check("R5 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_abort();
        logic a0, a1;
        int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        check("R6 no strobe mid byte", stb_cnt - s0, 0);
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        for (int i = 0; i < 8; i++) put_bit(1'b0);
        bus_stop();
        check("R6 no strobe before ack", stb_cnt - s0, 0);
    endtask

    task automatic t_read(input logic [7:0] v);
        logic a0, a1, a2, a3;
        logic [7:0] got;
        rd_data = v;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        bus_start();
        send_byte(8'hB1, a2);
        recv_byte(1'b0, got);
        check("R9 read address ack", a2, 1'b1);
        check("R9 read data", got, v);
        check("R9 line released", sda_oe, 1'b0);
        send_byte(8'hB1, a3);
        check("R9 idle after byte", a3, 1'b0);
        bus_stop();
    endtask

    task automatic t_busy();
        logic a0, a1, a2;
        int s0;
        s0 = stb_cnt;
        busy = 1'b1;
        bus_start();
        send_byte(8'hB0, a0);
        send_byte(8'hFF, a1);
        send_byte(8'h44, a2);
        bus_stop();
        busy = 1'b0;
        check("R8 no ack while busy", a0, 1'b0);
        check("R8 no strobe while busy", stb_cnt - s0, 0);
    endtask

    task automatic t_glitch();
        int st0;
        st0 = start_cnt;
        wclk(Q);
        sda_m = 1'b0; wclk(1); sda_m = 1'b1;
        wclk(4*Q);
        check("R12 glitch no start", start_cnt - st0, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wclk(2);
        t_reset();
        t_write(8'hC3);
        t_write(8'h5A);
        t_bad_dev();
        t_bad_reg();
        t_extra();
        t_write(8'h00);
        t_abort();
        t_read(8'hA5);
        t_read(8'h3C);
        t_busy();
        t_glitch();
        t_write(8'h81);
        check("R10 oe steady with clock high", oe_high_changes, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule